// File: doc/BRIEF.md
# Event timer comparator channel

This block is one comparator channel of a memory-mapped event timer. A free-running 64-bit main counter is supplied from outside. The channel compares that counter with a programmed match value and raises an interrupt on a hit. In one-shot mode it fires once per arming. In periodic mode it fires on every hit and then moves its own match value forward by a latched period, so software can read the time of the next interrupt from the value register.

Software reaches the channel through a simple 64-bit register bus. There is a configuration and capability word at channel offset 0x00, the value register at 0x08, and an unused route word at 0x10. The interrupt leaves the block either as a one-clock edge pulse or as a level held by a status bit. That status bit is this channel's slice of a shared interrupt status register. The shared decoder clears it with a write-1 strobe. A forced 32-bit mode narrows the compare and adds an interrupt when the low half of the counter wraps.

A small state machine tracks the arming. The states are ST_SPENT (reset state; one-shot has fired or was never armed), ST_ARMED (one-shot waiting for its match) and ST_PERIODIC (periodic, firing and reloading on every hit). The transitions are:
- T_ARM: a value-register write in one-shot mode goes to ST_ARMED.
- T_HIT: a match in ST_ARMED goes to ST_SPENT.
- T_TO_PERIODIC: a configuration write that sets the mode bit goes to ST_PERIODIC.
- T_TO_ONESHOT: a configuration write that clears the mode bit while in ST_PERIODIC goes to ST_ARMED.

Top module: `tmr_comparator_chan`

## Requirements
- R1: After reset, offset 0x00 reads 64'h0000_0F04_0000_0430, offset 0x08 reads all ones, slot_o is 2 (the lowest slot in the supported mask), and irq_o and stat_o are 0.
- R2: In one-shot mode (config bit 3 = 0) a value write arms the channel. The channel fires exactly once, on the clock edge that samples main_cnt_i equal to the match value. Later equal samples do not fire again until the value register is written again.
- R3: Config bit 2 enables the interrupt. When it is 0, no edge pulse is produced and a set status bit does not drive irq_o.
- R4: In periodic mode (config bit 3 = 1) every hit fires, and the match value becomes match + period on the same edge. Offset 0x08 then reads the next match.
- R5: With config bit 6 (set-value arm) at 1, a periodic value write loads both match and period, and bit 6 reads 0 afterwards. With bit 6 at 0, a periodic value write changes only the period.
- R6: With config bit 1 = 1 (level), a hit sets stat_o. stat_o stays set until a stat_clr_i pulse, and irq_o equals stat_o AND the enable bit.
- R7: With config bit 1 = 0 (edge), an enabled hit gives irq_o high for exactly one clock and stat_o stays 0.
- R8: With config bit 8 = 1, only bits 31:0 are compared and value writes keep only bits 31:0 (bits 63:32 read 0). A one-shot channel also fires when bit 31 of main_cnt_i falls from 1 to 0. That wrap interrupt does not occur with bit 8 = 0.
- R9: Bits 13:9 select the routing slot on slot_o. A write is taken only when bit <slot> of the supported mask 32'h0000_0F04 is 1; otherwise the old slot is kept.
- R10: Bits 4 (periodic capable, 1), 5 (64-bit counter, 1), 15 (message capable, 0) and 63:32 (supported mask) are read-only. Bits 0, 7 and 31:16 read 0. Bit 14 is held at 0 while message delivery is not offered. Writes to any of these bits have no effect.
- R11: Offset 0x10 and every unmapped offset read 0. Writes there change no register.
- R12: Clearing the enable bit does not stop periodic hits from advancing the match value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| main_cnt_i | input | 64 | Free-running main counter |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Byte offset inside the channel window |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data for addr_i (combinational) |
| stat_clr_i | input | 1 | Write-1-to-clear strobe for this channel's status bit |
| stat_o | output | 1 | This channel's bit of the shared status register |
| irq_o | output | 1 | Interrupt output, edge pulse or level |
| slot_o | output | 5 | Selected routing slot |

## Verification
The bench looks for an interrupt that comes one edge early or late, and for a one-shot channel that fires again when the counter passes the match a second time (the FSM failed to reach ST_SPENT). It checks that a periodic write without the arm bit leaves the match value alone, and that the arm bit clears itself. A design that mixed these up would read back the wrong next-hit time. In 32-bit mode the bench drives a wrap of bit 31 and checks that the upper bits of the value are dropped. It also checks that a 64-bit channel ignores the same wrap, which a careless wrap detector would not. Level status must survive until the clear strobe, and disabling the channel must mask irq_o while the periodic reload keeps moving.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned REG_W  = 64;
    localparam int unsigned OFS_W  = 5;
    localparam int unsigned SLOT_W = 5;

    localparam logic [OFS_W-1:0] OFS_CFG   = 5'h00;
    localparam logic [OFS_W-1:0] OFS_VAL   = 5'h08;
    localparam logic [OFS_W-1:0] OFS_ROUTE = 5'h10;

    typedef enum logic [1:0] {
        ST_SPENT    = 2'd0,
        ST_ARMED    = 2'd1,
        ST_PERIODIC = 2'd2
    } chan_state_e;

    typedef struct packed {
        logic              level;
        logic              enable;
        logic              periodic;
        logic              arm;
        logic              force32;
        logic              msg_en;
        logic [SLOT_W-1:0] slot;
    } chan_cfg_t;

endpackage

// File: rtl/tmr_cfg_regs.sv
module tmr_cfg_regs
    import tmr_pkg::*;
#(
    parameter logic [31:0] SLOT_MASK = 32'h0000_0F04,
    parameter logic        PER_CAP   = 1'b1,
    parameter logic        CNT64     = 1'b1,
    parameter logic        MSG_CAP   = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_i,
    input  logic             val_wr_i,
    input  logic [REG_W-1:0] wdata_i,
    output chan_cfg_t        cfg_o,
    output logic             mode_nxt_o,
    output logic [REG_W-1:0] cfg_word_o
);

    function automatic logic [SLOT_W-1:0] lowest_slot(input logic [31:0] m);
        logic [SLOT_W-1:0] r;
        r = '0;
        for (int i = 31; i >= 0; i--) begin
            if (m[i]) r = SLOT_W'(i);
        end
        return r;
    endfunction

    localparam chan_cfg_t CFG_RST = '{
        level:    1'b0,
        enable:   1'b0,
        periodic: 1'b0,
        arm:      1'b0,
        force32:  1'b0,
        msg_en:   1'b0,
        slot:     lowest_slot(SLOT_MASK)
    };

    chan_cfg_t         cfg_q, cfg_d;
    logic [SLOT_W-1:0] slot_req;
    logic              unused_wd;

    assign slot_req  = wdata_i[13:9];
    assign unused_wd = ^{wdata_i[63:15], wdata_i[7], wdata_i[5:4], wdata_i[0]};

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_wr_i) begin
            cfg_d.level    = wdata_i[1];
            cfg_d.enable   = wdata_i[2];
            cfg_d.periodic = PER_CAP ? wdata_i[3] : 1'b0;
            cfg_d.arm      = wdata_i[6];
            cfg_d.force32  = CNT64 ? wdata_i[8] : 1'b0;
            cfg_d.msg_en   = MSG_CAP ? wdata_i[14] : 1'b0;
            if (SLOT_MASK[slot_req]) begin
                cfg_d.slot = slot_req;
            end
        end else if (val_wr_i) begin
            cfg_d.arm = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o      = cfg_q;
    assign mode_nxt_o = cfg_d.periodic;

    assign cfg_word_o = {SLOT_MASK, 16'h0000, MSG_CAP, cfg_q.msg_en, cfg_q.slot,
                         cfg_q.force32, 1'b0, cfg_q.arm, CNT64, PER_CAP,
                         cfg_q.periodic, cfg_q.enable, cfg_q.level, 1'b0};

    AST_ARM_SELFCLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (val_wr_i && !cfg_wr_i && cfg_q.arm) |=> !cfg_q.arm); // R5

    AST_SLOT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        SLOT_MASK[cfg_q.slot]); // R9

endmodule

// File: rtl/tmr_match.sv
module tmr_match
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W = REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             val_wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             periodic_i,
    input  logic             arm_i,
    input  logic             wide32_i,
    input  logic             reload_i,
    output logic [CNT_W-1:0] match_o,
    output logic             eq_o,
    output logic             wrap_o
);

    localparam int unsigned HALF_W = CNT_W / 2;

    logic [CNT_W-1:0] match_q, period_q;
    logic [CNT_W-1:0] keep_mask, wr_masked, next_sum;
    logic             top_prev_q;

    always_comb begin
        keep_mask = wide32_i ? {{(CNT_W-HALF_W){1'b0}}, {HALF_W{1'b1}}} : {CNT_W{1'b1}};
        wr_masked = wdata_i & keep_mask;
        next_sum  = (match_q + period_q) & keep_mask;
        eq_o      = ((cnt_i ^ match_q) & keep_mask) == '0;
        wrap_o    = wide32_i && top_prev_q && !cnt_i[HALF_W-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q    <= {CNT_W{1'b1}};
            period_q   <= '0;
            top_prev_q <= 1'b0;
        end else begin
            top_prev_q <= cnt_i[HALF_W-1];
            if (val_wr_i) begin
                if (periodic_i) begin
                    period_q <= wr_masked;
                    if (arm_i) begin
                        match_q <= wr_masked;
                    end
                end else begin
                    match_q <= wr_masked;
                end
            end else if (reload_i) begin
                match_q <= next_sum;
            end
        end
    end

    assign match_o = match_q;

    AST_RELOAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_i && !val_wr_i) |=>
            (match_q == (($past(match_q) + $past(period_q)) & $past(keep_mask)))); // R4

    AST_WIDE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (val_wr_i && wide32_i && (!periodic_i || arm_i)) |=>
            (match_q[CNT_W-1:HALF_W] == '0)); // R8

endmodule

// File: rtl/tmr_chan_fsm.sv
module tmr_chan_fsm
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_nxt_i,
    input  logic val_wr_i,
    input  logic eq_i,
    input  logic wrap_i,
    output logic fire_o,
    output logic reload_o
);

    chan_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SPENT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SPENT:    state_d = ST_SPENT;
            ST_ARMED:    if (eq_i) state_d = ST_SPENT;
            ST_PERIODIC: state_d = ST_PERIODIC;
            default:     state_d = ST_SPENT;
        endcase
        if (mode_nxt_i) begin
            state_d = ST_PERIODIC;
        end else if (state_q == ST_PERIODIC) begin
            state_d = ST_ARMED;
        end else if (val_wr_i) begin
            state_d = ST_ARMED;
        end
    end

    always_comb begin
        fire_o   = 1'b0;
        reload_o = 1'b0;
        unique case (state_q)
            ST_SPENT:    fire_o = wrap_i;
            ST_ARMED:    fire_o = eq_i || wrap_i;
            ST_PERIODIC: begin
                fire_o   = eq_i;
                reload_o = eq_i;
            end
            default:     fire_o = 1'b0;
        endcase
    end

    AST_ONESHOT_SPENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && eq_i && !val_wr_i && !mode_nxt_i) |=> (state_q == ST_SPENT)); // R2

    AST_PERIODIC_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_nxt_i |=> (state_q == ST_PERIODIC)); // R4

endmodule

// File: rtl/tmr_irq_out.sv
module tmr_irq_out (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    input  logic level_i,
    input  logic enable_i,
    input  logic stat_clr_i,
    output logic stat_o,
    output logic irq_o
);

    logic stat_q, pulse_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= fire_i && enable_i && !level_i;
            if (fire_i && level_i) begin
                stat_q <= 1'b1;
            end else if (stat_clr_i) begin
                stat_q <= 1'b0;
            end
        end
    end

    always_comb begin
        irq_o  = level_i ? (stat_q && enable_i) : pulse_q;
        stat_o = stat_q;
    end

    AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q && !stat_clr_i) |=> stat_q); // R6

    AST_STAT_LEVEL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q) |-> $past(fire_i && level_i)); // R7

    AST_EDGE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_i && irq_o) |-> $past(enable_i)); // R3

endmodule

// File: rtl/tmr_comparator_chan.sv
module tmr_comparator_chan
    import tmr_pkg::*;
#(
    parameter logic [31:0] SLOT_MASK = 32'h0000_0F04,
    parameter logic        PER_CAP   = 1'b1,
    parameter logic        CNT64     = 1'b1,
    parameter logic        MSG_CAP   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  main_cnt_i,
    input  logic              wr_en_i,
    input  logic [OFS_W-1:0]  addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  rdata_o,
    input  logic              stat_clr_i,
    output logic              stat_o,
    output logic              irq_o,
    output logic [SLOT_W-1:0] slot_o
);

    chan_cfg_t        cfg;
    logic             cfg_wr, val_wr, mode_nxt;
    logic [REG_W-1:0] cfg_word, match_val;
    logic             eq, wrap, fire, reload, wide32;
    logic             unused_top;

    assign cfg_wr     = wr_en_i && (addr_i == OFS_CFG);
    assign val_wr     = wr_en_i && (addr_i == OFS_VAL);
    assign wide32     = cfg.force32 || !CNT64;
    assign unused_top = cfg.msg_en;

    tmr_cfg_regs #(
        .SLOT_MASK (SLOT_MASK),
        .PER_CAP   (PER_CAP),
        .CNT64     (CNT64),
        .MSG_CAP   (MSG_CAP)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr_i   (cfg_wr),
        .val_wr_i   (val_wr),
        .wdata_i    (wdata_i),
        .cfg_o      (cfg),
        .mode_nxt_o (mode_nxt),
        .cfg_word_o (cfg_word)
    );

    tmr_match #(
        .CNT_W (REG_W)
    ) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_i      (main_cnt_i),
        .val_wr_i   (val_wr),
        .wdata_i    (wdata_i),
        .periodic_i (cfg.periodic),
        .arm_i      (cfg.arm),
        .wide32_i   (wide32),
        .reload_i   (reload),
        .match_o    (match_val),
        .eq_o       (eq),
        .wrap_o     (wrap)
    );

    tmr_chan_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_nxt_i (mode_nxt),
        .val_wr_i   (val_wr),
        .eq_i       (eq),
        .wrap_i     (wrap),
        .fire_o     (fire),
        .reload_o   (reload)
    );

    tmr_irq_out u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire_i     (fire),
        .level_i    (cfg.level),
        .enable_i   (cfg.enable),
        .stat_clr_i (stat_clr_i),
        .stat_o     (stat_o),
        .irq_o      (irq_o)
    );

    always_comb begin
        case (addr_i)
            OFS_CFG: rdata_o = cfg_word;
            OFS_VAL: rdata_o = match_val;
            default: rdata_o = '0;
        endcase
    end

    assign slot_o = cfg.slot;

endmodule

// File: tb/tmr_comparator_chan_bench.sv
module tmr_comparator_chan_bench;

    localparam int K_IRQ  = 0;
    localparam int K_STAT = 1;
    localparam int K_RD   = 2;
    localparam int K_SLOT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] cnt = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic        stat_clr = 1'b0;
    logic        stat, irq;
    logic [4:0]  slot;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int          kind_q[$];
    logic [63:0] exp_q[$];
    string       req_q[$];

    always #5 clk = ~clk;

    tmr_comparator_chan u_tmr_comparator_chan (
        .clk        (clk),
        .rst_n      (rst_n),
        .main_cnt_i (cnt),
        .wr_en_i    (wr_en),
        .addr_i     (addr),
        .wdata_i    (wdata),
        .rdata_o    (rdata),
        .stat_clr_i (stat_clr),
        .stat_o     (stat),
        .irq_o      (irq),
        .slot_o     (slot)
    );

    // monitor: pops every expectation queued this cycle and compares at negedge
    always @(negedge clk) begin
        int          k;
        logic [63:0] e, act;
        string       r;
        while (kind_q.size() > 0) begin
            k = kind_q.pop_front();
            e = exp_q.pop_front();
            r = req_q.pop_front();
            case (k)
                K_IRQ:   act = {63'd0, irq};
                K_STAT:  act = {63'd0, stat};
                K_RD:    act = rdata;
                default: act = {59'd0, slot};
            endcase
            n_run++;
            if (act !== e) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", r, act, e);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
        wr_en    = 1'b0;
        stat_clr = 1'b0;
    endtask

    task automatic push(int k, logic [63:0] e, string r);
        kind_q.push_back(k);
        exp_q.push_back(e);
        req_q.push_back(r);
    endtask

    task automatic reg_wr(logic [4:0] a, logic [63:0] d);
        tick();
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        tick();
    endtask

    task automatic reg_rd(logic [4:0] a, logic [63:0] e, string r);
        tick();
        addr = a;
        push(K_RD, e, r);
    endtask

    task automatic cnt_to(logic [63:0] v);
        tick();
        cnt = v;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1 reset state
        reg_rd(5'h00, 64'h0000_0F04_0000_0430, "R1 cfg reset");
        push(K_IRQ, 64'd0, "R1 irq reset");
        push(K_STAT, 64'd0, "R1 stat reset");
        push(K_SLOT, 64'd2, "R1 slot reset");
        reg_rd(5'h08, {64{1'b1}}, "R1 value reset");

        // R10 read-only and reserved bits
        reg_wr(5'h00, {64{1'b1}});
        reg_rd(5'h00, 64'h0000_0F04_0000_057E, "R10 ro/reserved bits");

        // R9 slot acceptance
        reg_wr(5'h00, 64'h1000);
        reg_rd(5'h00, 64'h0000_0F04_0000_1030, "R9 slot 8 accepted");
        push(K_SLOT, 64'd8, "R9 slot_o 8");
        reg_wr(5'h00, 64'hA00);
        reg_rd(5'h00, 64'h0000_0F04_0000_1030, "R9 slot 5 refused");
        push(K_SLOT, 64'd8, "R9 slot_o kept");

        // R11 route and unmapped offsets
        reg_wr(5'h10, {64{1'b1}});
        reg_rd(5'h10, 64'd0, "R11 route reads 0");
        reg_rd(5'h18, 64'd0, "R11 unmapped reads 0");
        reg_rd(5'h00, 64'h0000_0F04_0000_1030, "R11 cfg untouched");
        reg_rd(5'h08, {64{1'b1}}, "R11 value untouched");

        // R2 / R7 one-shot edge
        reg_wr(5'h00, 64'h1004);
        reg_wr(5'h08, 64'h100);
        cnt_to(64'hFF);
        cnt_to(64'h100);
        push(K_IRQ, 64'd0, "R2 no early fire");
        cnt_to(64'h101);
        push(K_IRQ, 64'd1, "R2 fire on match");
        push(K_STAT, 64'd0, "R7 edge leaves stat clear");
        cnt_to(64'h102);
        push(K_IRQ, 64'd0, "R7 single-clock pulse");
        cnt_to(64'h100);
        cnt_to(64'h101);
        push(K_IRQ, 64'd0, "R2 no second fire");
        cnt_to(64'hFFFF_FFFF);
        cnt_to(64'h1_0000_0000);
        cnt_to(64'h1_0000_0001);
        push(K_IRQ, 64'd0, "R8 no wrap fire in 64-bit mode");

        // R3 / R6 level mode
        reg_wr(5'h00, 64'h1002);
        reg_wr(5'h08, 64'h200);
        cnt_to(64'h200);
        cnt_to(64'h201);
        push(K_STAT, 64'd1, "R6 status set on hit");
        push(K_IRQ, 64'd0, "R3 disabled masks level");
        cnt_to(64'h202);
        cnt_to(64'h203);
        push(K_STAT, 64'd1, "R6 status held");
        reg_wr(5'h00, 64'h1006);
        push(K_IRQ, 64'd1, "R6 irq follows status when enabled");
        tick();
        stat_clr = 1'b1;
        tick();
        push(K_STAT, 64'd0, "R6 status cleared");
        push(K_IRQ, 64'd0, "R6 irq drops after clear");

        // R4 / R5 periodic
        reg_wr(5'h00, 64'h104C);
        reg_wr(5'h08, 64'h400);
        reg_rd(5'h00, 64'h0000_0F04_0000_103C, "R5 arm self-clears");
        reg_rd(5'h08, 64'h400, "R5 armed write loads match");
        cnt_to(64'h400);
        cnt_to(64'h401);
        push(K_IRQ, 64'd1, "R4 first periodic hit");
        reg_rd(5'h08, 64'h800, "R4 match advanced by period");
        reg_wr(5'h08, 64'h10);
        reg_rd(5'h08, 64'h800, "R5 unarmed write leaves match");
        cnt_to(64'h800);
        cnt_to(64'h801);
        push(K_IRQ, 64'd1, "R4 second periodic hit");
        reg_rd(5'h08, 64'h810, "R5 new period used");

        // R12 disabled periodic keeps reloading
        reg_wr(5'h00, 64'h1008);
        cnt_to(64'h810);
        cnt_to(64'h811);
        push(K_IRQ, 64'd0, "R3 disabled edge no pulse");
        reg_rd(5'h08, 64'h820, "R12 reload while disabled");

        // R8 32-bit mode
        reg_wr(5'h00, 64'h1104);
        reg_wr(5'h08, 64'hABCD_0000_0000_0050);
        reg_rd(5'h08, 64'h50, "R8 upper bits dropped");
        cnt_to(64'h7_0000_0050);
        cnt_to(64'h7_0000_0051);
        push(K_IRQ, 64'd1, "R8 low-half compare");
        cnt_to(64'h7_FFFF_FFFF);
        push(K_IRQ, 64'd0, "R8 quiet before wrap");
        cnt_to(64'h8_0000_0000);
        cnt_to(64'h8_0000_0001);
        push(K_IRQ, 64'd1, "R8 wrap fire");
        cnt_to(64'h8_0000_0002);
        push(K_IRQ, 64'd0, "R8 wrap pulse ends");

        tick();
        tick();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule